// File: doc/BRIEF.md
# Banked Stack Pointer Push/Pop Unit

This block keeps two word-aligned stack pointers, a main pointer and a process pointer, and decides which of them is active from the processor mode and a stack-select control bit. The stack is full-descending. The active pointer always holds the address of the most recently stored word.

A push or pop request carries a 16-bit register mask. The unit walks the mask from the lowest-numbered register upward. It moves one 32-bit word per cycle between a register-file port and a synchronous memory port, and it adjusts the pointer that was active when the request was taken. A side port lets privileged software read or write either pointer directly, whatever the current mode. An operating-system kernel running in handler mode can therefore find the stacked context of the interrupted task.

Top module: `bsp_stack_unit`

## Requirements
- R1: After reset both pointers hold `rst_sp_val` with bits [1:0] cleared. `stack_sel` is 0 and `busy` and `done` are low.
- R2: The active pointer (`sp_active`) is the main pointer when `stack_sel` is 0, or when `handler_mode` is 1. It is the process pointer only when `stack_sel` is 1 and `handler_mode` is 0.
- R3: A push of N registers lowers the active pointer by 4·N when it starts. It then stores the set registers in ascending register number at ascending addresses, starting at the new pointer, so the lowest-numbered register sits at the lowest address.
- R4: A pop of N registers loads the set registers in ascending register number from ascending addresses, starting at the current pointer. When the last load has landed it raises that pointer by 4·N. A push followed by a pop with the same mask restores the registers and the pointer.
- R5: Bits [1:0] of both pointers read as 0 at all times, including after a direct write with those bits set, and every memory address is word aligned.
- R6: The pointer port reads and writes the pointer picked by `ptr_rd_psp` or `ptr_wr_psp` (1 = process, 0 = main), independent of the mode and of `stack_sel`.
- R7: One memory word moves per cycle. For a non-empty mask, `busy` is high for N cycles on a push and N+1 cycles on a pop, starting in the cycle after acceptance. `done` pulses for one cycle as `busy` falls.
- R8: Requests presented while `busy` is high are ignored. They change neither the running sequence nor its result.
- R9: A request with an empty mask produces `done` in the cycle after acceptance. `busy` stays low, no memory request is made and neither pointer changes.
- R10: A direct pointer write is ignored while `busy` is high, and also in a cycle where a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_sp_val | input | 32 | Reset value for both pointers |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| sel_wr_en | input | 1 | Write enable for the stack-select bit |
| sel_wr_val | input | 1 | New stack-select value |
| stack_sel | output | 1 | Current stack-select bit |
| sp_active | output | 32 | Currently active pointer |
| ptr_rd_psp | input | 1 | Pointer port read select (1 = process) |
| ptr_rd_data | output | 32 | Pointer port read data |
| ptr_wr_en | input | 1 | Pointer port write enable |
| ptr_wr_psp | input | 1 | Pointer port write select (1 = process) |
| ptr_wr_data | input | 32 | Pointer port write data |
| op_valid | input | 1 | Push/pop request |
| op_pop | input | 1 | 1 = pop, 0 = push |
| op_mask | input | 16 | Register list, bit i = register i |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |

## Verification
The main function is tried with four kinds of request:
- a single-register push and pop, which fixes the basic pointer step and cycle count;
- a sparse four-register mask, which separates ascending from descending placement and exposes a wrong 4·N scaling;
- an empty mask, which shows that the block completes without touching memory;
- pushes and pops on the process pointer, in both thread and handler mode, which tell a correct bank choice apart from one that ignores the mode.

A run where the request lines and a pointer write stay active with conflicting values during a sequence shows whether any of that noise leaks into memory contents, register values or pointers.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_XFER  = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_e;
endpackage

// File: rtl/bsp_mask_scan.sv
module bsp_mask_scan #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG),
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask,
  output logic [IDX_W-1:0] low_idx,
  output logic [CNT_W-1:0] set_cnt
);
  // lowest set bit: scan downward so the smallest index wins
  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) low_idx = IDX_W'(i);
    end
  end

  always_comb begin
    set_cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      set_cnt = set_cnt + CNT_W'(mask[i]);
    end
  end
endmodule

// File: rtl/bsp_ptr_bank.sv
module bsp_ptr_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [DW-1:0] rst_val,
  input  logic          handler_mode,
  input  logic          sel_we,
  input  logic          sel_d,
  input  logic          upd_en,
  input  logic          upd_psp,
  input  logic [DW-1:0] upd_val,
  input  logic          lock,
  input  logic          ext_we,
  input  logic          ext_psp,
  input  logic [DW-1:0] ext_val,
  input  logic          rd_psp,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] act_val,
  output logic          act_psp,
  output logic          sel_q
);
  localparam logic [DW-1:0] ALIGN_MASK = ~DW'(3);

  logic [DW-1:0] msp_q, msp_d, psp_q, psp_d;
  logic          msp_en, psp_en;
  logic          ext_ok;

  assign ext_ok = ext_we && !lock;

  // next-state: the sequencer update has priority over the side port
  always_comb begin
    msp_en = 1'b0;
    psp_en = 1'b0;
    msp_d  = msp_q;
    psp_d  = psp_q;
    if (upd_en) begin
      if (upd_psp) begin
        psp_en = 1'b1;
        psp_d  = upd_val & ALIGN_MASK;
      end else begin
        msp_en = 1'b1;
        msp_d  = upd_val & ALIGN_MASK;
      end
    end else if (ext_ok) begin
      if (ext_psp) begin
        psp_en = 1'b1;
        psp_d  = ext_val & ALIGN_MASK;
      end else begin
        msp_en = 1'b1;
        msp_d  = ext_val & ALIGN_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      msp_q <= rst_val & ALIGN_MASK;
      psp_q <= rst_val & ALIGN_MASK;
      sel_q <= 1'b0;
    end else begin
      if (msp_en) msp_q <= msp_d;
      if (psp_en) psp_q <= psp_d;
      if (sel_we) sel_q <= sel_d;
    end
  end

  assign act_psp = sel_q && !handler_mode;
  assign act_val = act_psp ? psp_q : msp_q;
  assign rd_val  = rd_psp ? psp_q : msp_q;

  // R2: handler mode never runs on the process pointer
  a_r2_handler_main: assert property (@(posedge clk) disable iff (!rst_ni)
    handler_mode |-> (act_val == msp_q));
  // R2: thread mode with select set runs on the process pointer
  a_r2_thread_proc: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_q && !handler_mode) |-> (act_val == psp_q));
  // R5: both pointers stay word aligned
  a_r5_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_ni)
    (msp_q[1:0] == 2'b00) && (psp_q[1:0] == 2'b00));
  // R10: while locked, only the sequencer may move a pointer
  a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock && !upd_en) |=> ($stable(msp_q) && $stable(psp_q)));
endmodule

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG),
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             op_valid,
  input  logic             op_pop,
  input  logic [NREG-1:0]  op_mask,
  input  logic [DW-1:0]    act_ptr,
  input  logic             act_psp,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [IDX_W-1:0] rf_rd_idx,
  input  logic [DW-1:0]    rf_rd_data,
  output logic             rf_wr_en,
  output logic [IDX_W-1:0] rf_wr_idx,
  output logic [DW-1:0]    rf_wr_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             upd_en,
  output logic             upd_psp,
  output logic [DW-1:0]    upd_val
);
  localparam logic [DW-1:0] WORD_BYTES = DW'(4);

  sq_state_e        state_q, state_d;
  logic [NREG-1:0]  rem_q, rem_d;
  logic             rem_en;
  logic [DW-1:0]    addr_q, addr_d;
  logic             addr_en;
  logic [DW-1:0]    fin_q, fin_d;
  logic             pop_q, bank_q, op_en;
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] pidx_q, pidx_d;
  logic             done_q, done_d;

  logic [IDX_W-1:0] rem_low, req_low;
  logic [CNT_W-1:0] rem_cnt, req_cnt;
  logic [DW-1:0]    span;
  logic [NREG-1:0]  rem_after;

  bsp_mask_scan #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan_rem (
    .mask(rem_q), .low_idx(rem_low), .set_cnt(rem_cnt)
  );

  bsp_mask_scan #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan_req (
    .mask(op_mask), .low_idx(req_low), .set_cnt(req_cnt)
  );

  assign span      = DW'(req_cnt) << 2;
  assign rem_after = rem_q & ~(NREG'(1) << rem_low);
  assign accept    = (state_q == SQ_IDLE) && op_valid;

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    rem_en    = 1'b0;
    addr_d    = addr_q;
    addr_en   = 1'b0;
    fin_d     = fin_q;
    op_en     = 1'b0;
    pend_d    = 1'b0;
    pidx_d    = pidx_q;
    done_d    = 1'b0;
    upd_en    = 1'b0;
    upd_psp   = act_psp;
    upd_val   = act_ptr;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = rf_rd_data;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          if (req_cnt == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = SQ_XFER;
            op_en   = 1'b1;
            rem_en  = 1'b1;
            rem_d   = op_mask;
            addr_en = 1'b1;
            if (op_pop) begin
              addr_d = act_ptr;
              fin_d  = act_ptr + span;
            end else begin
              addr_d  = act_ptr - span;
              upd_en  = 1'b1;
              upd_psp = act_psp;
              upd_val = act_ptr - span;
            end
          end
        end
      end
      SQ_XFER: begin
        mem_req = 1'b1;
        mem_we  = !pop_q;
        rem_en  = 1'b1;
        rem_d   = rem_after;
        addr_en = 1'b1;
        addr_d  = addr_q + WORD_BYTES;
        if (pop_q) begin
          pend_d = 1'b1;
          pidx_d = rem_low;
        end
        if (rem_cnt == CNT_W'(1)) begin
          if (pop_q) begin
            state_d = SQ_DRAIN;
          end else begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      SQ_DRAIN: begin
        state_d = SQ_IDLE;
        done_d  = 1'b1;
        upd_en  = 1'b1;
        upd_psp = bank_q;
        upd_val = fin_q;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      fin_q   <= '0;
      pop_q   <= 1'b0;
      bank_q  <= 1'b0;
      pend_q  <= 1'b0;
      pidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      pidx_q  <= pidx_d;
      done_q  <= done_d;
      if (rem_en)  rem_q  <= rem_d;
      if (addr_en) addr_q <= addr_d;
      if (op_en) begin
        fin_q  <= fin_d;
        pop_q  <= op_pop;
        bank_q <= act_psp;
      end
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign done       = done_q;
  assign rf_rd_idx  = rem_low;
  assign rf_wr_en   = pend_q;
  assign rf_wr_idx  = pidx_q;
  assign rf_wr_data = mem_rdata;

  // R3/R4: consecutive words of one sequence go to consecutive ascending words
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_XFER && $past(state_q) == SQ_XFER) |-> (mem_addr == $past(mem_addr) + WORD_BYTES));
  // R7: each transfer cycle retires exactly one register
  a_r7_walk_shrinks: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_XFER && $past(state_q) == SQ_XFER) |-> ($countones(rem_q) == $countones($past(rem_q)) - 1));
  // R5: memory addresses are word aligned
  a_r5_mem_aligned: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  // R9: an empty list completes at once with no memory access
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_IDLE && op_valid && op_mask == '0) |=> (done && !busy && !mem_req));
  // R8: a request during a sequence does not restart it
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_XFER && op_valid) |=> ($countones(rem_q) < $countones($past(rem_q))));
  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
endmodule

// File: rtl/bsp_stack_unit.sv
module bsp_stack_unit #(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG),
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rst_sp_val,
  input  logic             handler_mode,
  input  logic             sel_wr_en,
  input  logic             sel_wr_val,
  output logic             stack_sel,
  output logic [DW-1:0]    sp_active,
  input  logic             ptr_rd_psp,
  output logic [DW-1:0]    ptr_rd_data,
  input  logic             ptr_wr_en,
  input  logic             ptr_wr_psp,
  input  logic [DW-1:0]    ptr_wr_data,
  input  logic             op_valid,
  input  logic             op_pop,
  input  logic [NREG-1:0]  op_mask,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] rf_rd_idx,
  input  logic [DW-1:0]    rf_rd_data,
  output logic             rf_wr_en,
  output logic [IDX_W-1:0] rf_wr_idx,
  output logic [DW-1:0]    rf_wr_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic          act_psp, upd_en, upd_psp, accept, lock;
  logic [DW-1:0] upd_val;

  assign lock = busy || accept;

  bsp_ptr_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst_ni(rst_ni), .rst_val(rst_sp_val),
    .handler_mode(handler_mode),
    .sel_we(sel_wr_en), .sel_d(sel_wr_val),
    .upd_en(upd_en), .upd_psp(upd_psp), .upd_val(upd_val),
    .lock(lock),
    .ext_we(ptr_wr_en), .ext_psp(ptr_wr_psp), .ext_val(ptr_wr_data),
    .rd_psp(ptr_rd_psp), .rd_val(ptr_rd_data),
    .act_val(sp_active), .act_psp(act_psp), .sel_q(stack_sel)
  );

  bsp_seq #(.DW(DW), .NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_ni(rst_ni),
    .op_valid(op_valid), .op_pop(op_pop), .op_mask(op_mask),
    .act_ptr(sp_active), .act_psp(act_psp),
    .busy(busy), .done(done), .accept(accept),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .upd_en(upd_en), .upd_psp(upd_psp), .upd_val(upd_val)
  );

  // R1: out of reset nothing is running
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy && !done));
  // R7: memory is only driven during a sequence
  a_r7_req_in_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> busy);
endmodule

// File: tb/bsp_stack_unit_tb_top.sv
module bsp_stack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] rst_sp_val;
  logic        handler_mode, sel_wr_en, sel_wr_val, stack_sel;
  logic [31:0] sp_active, ptr_rd_data, ptr_wr_data;
  logic        ptr_rd_psp, ptr_wr_en, ptr_wr_psp;
  logic        op_valid, op_pop, busy, done;
  logic [15:0] op_mask;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data;
  logic        rf_wr_en, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  logic [31:0] rf  [16];
  logic [31:0] mem [512];

  always #2 clk = ~clk;

  bsp_stack_unit dut_i (.*);

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[10:2]];
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL ALL watchdog expired: actual %0d cycles expected < 20000", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] rv(input int i);
    return 32'hA500_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd_ptr(input logic psp, output logic [31:0] v);
    ptr_rd_psp = psp;
    #0.5;
    v = ptr_rd_data;
  endtask

  task automatic wr_ptr(input logic psp, input logic [31:0] v);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_psp = psp; ptr_wr_data = v;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk);
    sel_wr_en = 1'b1; sel_wr_val = v;
    @(negedge clk);
    sel_wr_en = 1'b0;
  endtask

  task automatic clobber(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) rf[i] = 32'hDEAD_0000 | 32'(i);
  endtask

  // noisy: keep request lines active with conflicting values and try a pointer write
  task automatic run_op(input logic pop, input logic [15:0] m, input bit noisy,
                        output int cyc, output int nreq, output int nbusy);
    @(negedge clk);
    op_pop = pop; op_mask = m; op_valid = 1'b1;
    @(negedge clk);
    cyc = 1; nreq = 0; nbusy = 0;
    if (noisy) begin
      op_pop = ~pop; op_mask = 16'hFFFF;
      ptr_wr_en = 1'b1; ptr_wr_psp = 1'b0; ptr_wr_data = 32'h1234_5670;
    end else begin
      op_valid = 1'b0;
    end
    while (!done) begin
      if (mem_req) nreq++;
      if (busy) nbusy++;
      @(negedge clk);
      cyc++;
    end
    op_valid = 1'b0; ptr_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "stack_sel", 32'(stack_sel), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    rd_ptr(1'b0, v); chk("R1", "main ptr", v, 32'h0000_0400);
    rd_ptr(1'b1, v); chk("R1", "proc ptr", v, 32'h0000_0400);
  endtask

  task automatic t_select();
    logic [31:0] v;
    wr_ptr(1'b1, 32'h0000_02F2);
    rd_ptr(1'b1, v); chk("R5", "proc ptr after unaligned write", v, 32'h0000_02F0);
    handler_mode = 1'b0; #0.5;
    chk("R2", "thread sel=0 active", sp_active, 32'h0000_0400);
    set_sel(1'b1); #0.5;
    chk("R2", "thread sel=1 active", sp_active, 32'h0000_02F0);
    handler_mode = 1'b1; #0.5;
    chk("R2", "handler sel=1 active", sp_active, 32'h0000_0400);
    rd_ptr(1'b1, v); chk("R6", "proc ptr read in handler", v, 32'h0000_02F0);
    handler_mode = 1'b0;
    set_sel(1'b0);
  endtask

  task automatic t_push_pop_main();
    int c, r, b;
    logic [31:0] v;
    run_op(1'b0, 16'h0020, 1'b0, c, r, b);
    rd_ptr(1'b0, v); chk("R3", "single push ptr", v, 32'h0000_03FC);
    chk("R3", "single push word", mem[9'(32'h3FC >> 2)], rv(5));
    chk("R7", "single push cycles", 32'(c), 32'd2);
    chk("R7", "single push busy", 32'(b), 32'd1);
    run_op(1'b0, 16'h108A, 1'b0, c, r, b);
    rd_ptr(1'b0, v); chk("R3", "multi push ptr", v, 32'h0000_03EC);
    chk("R3", "multi push r1 lowest", mem[9'(32'h3EC >> 2)], rv(1));
    chk("R3", "multi push r3", mem[9'(32'h3F0 >> 2)], rv(3));
    chk("R3", "multi push r7", mem[9'(32'h3F4 >> 2)], rv(7));
    chk("R3", "multi push r12", mem[9'(32'h3F8 >> 2)], rv(12));
    chk("R7", "multi push words", 32'(r), 32'd4);
    chk("R7", "multi push busy", 32'(b), 32'd4);
    clobber(16'h10AA);
    run_op(1'b1, 16'h108A, 1'b0, c, r, b);
    rd_ptr(1'b0, v); chk("R4", "multi pop ptr", v, 32'h0000_03FC);
    chk("R4", "pop r1", rf[1], rv(1));
    chk("R4", "pop r3", rf[3], rv(3));
    chk("R4", "pop r7", rf[7], rv(7));
    chk("R4", "pop r12", rf[12], rv(12));
    chk("R4", "pop leaves r5", rf[5], 32'hDEAD_0005);
    chk("R7", "multi pop cycles", 32'(c), 32'd6);
    chk("R7", "multi pop busy", 32'(b), 32'd5);
    run_op(1'b1, 16'h0020, 1'b0, c, r, b);
    rd_ptr(1'b0, v); chk("R4", "LIFO final ptr", v, 32'h0000_0400);
    chk("R4", "LIFO r5", rf[5], rv(5));
  endtask

  task automatic t_empty();
    int c, r, b;
    logic [31:0] v;
    run_op(1'b0, 16'h0000, 1'b0, c, r, b);
    chk("R9", "empty push cycles", 32'(c), 32'd1);
    chk("R9", "empty push mem_req", 32'(mem_req), 32'd0);
    chk("R9", "empty push busy", 32'(busy), 32'd0);
    rd_ptr(1'b0, v); chk("R9", "empty push ptr", v, 32'h0000_0400);
    run_op(1'b1, 16'h0000, 1'b0, c, r, b);
    chk("R9", "empty pop cycles", 32'(c), 32'd1);
    rd_ptr(1'b0, v); chk("R9", "empty pop ptr", v, 32'h0000_0400);
  endtask

  task automatic t_proc_stack();
    int c, r, b;
    logic [31:0] v;
    set_sel(1'b1);
    handler_mode = 1'b0;
    run_op(1'b0, 16'h0005, 1'b0, c, r, b);
    rd_ptr(1'b1, v); chk("R2", "thread push moves proc ptr", v, 32'h0000_02E8);
    rd_ptr(1'b0, v); chk("R2", "thread push keeps main", v, 32'h0000_0400);
    chk("R3", "proc push r0", mem[9'(32'h2E8 >> 2)], rv(0));
    chk("R3", "proc push r2", mem[9'(32'h2EC >> 2)], rv(2));
    handler_mode = 1'b1;
    run_op(1'b0, 16'h0010, 1'b0, c, r, b);
    rd_ptr(1'b0, v); chk("R2", "handler push moves main", v, 32'h0000_03FC);
    rd_ptr(1'b1, v); chk("R2", "handler push keeps proc", v, 32'h0000_02E8);
    clobber(16'h0015);
    run_op(1'b1, 16'h0010, 1'b0, c, r, b);
    rd_ptr(1'b0, v); chk("R4", "handler pop main", v, 32'h0000_0400);
    chk("R4", "handler pop r4", rf[4], rv(4));
    handler_mode = 1'b0;
    run_op(1'b1, 16'h0005, 1'b0, c, r, b);
    rd_ptr(1'b1, v); chk("R4", "thread pop proc", v, 32'h0000_02F0);
    chk("R4", "thread pop r0", rf[0], rv(0));
    chk("R4", "thread pop r2", rf[2], rv(2));
    set_sel(1'b0);
  endtask

  task automatic t_busy_ignore();
    int c, r, b;
    logic [31:0] v;
    run_op(1'b0, 16'h0003, 1'b1, c, r, b);
    rd_ptr(1'b0, v); chk("R10", "push ptr despite side write", v, 32'h0000_03F8);
    chk("R8", "noisy push cycles", 32'(c), 32'd3);
    chk("R8", "noisy push r0", mem[9'(32'h3F8 >> 2)], rv(0));
    chk("R8", "noisy push r1", mem[9'(32'h3FC >> 2)], rv(1));
    clobber(16'h0003);
    run_op(1'b1, 16'h0003, 1'b1, c, r, b);
    rd_ptr(1'b0, v); chk("R10", "pop ptr despite side write", v, 32'h0000_0400);
    chk("R8", "noisy pop cycles", 32'(c), 32'd4);
    chk("R8", "noisy pop r0", rf[0], rv(0));
    chk("R8", "noisy pop r1", rf[1], rv(1));
    chk("R8", "noisy pop leaves r9", rf[9], rv(9));
    rd_ptr(1'b1, v); chk("R8", "proc ptr untouched", v, 32'h0000_02F0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = rv(i);
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    mem_rdata = 32'h0;
    rst_sp_val = 32'h0000_0403;
    handler_mode = 1'b0; sel_wr_en = 1'b0; sel_wr_val = 1'b0;
    ptr_rd_psp = 1'b0; ptr_wr_en = 1'b0; ptr_wr_psp = 1'b0; ptr_wr_data = 32'h0;
    op_valid = 1'b0; op_pop = 1'b0; op_mask = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_select();
    t_push_pop_main();
    t_empty();
    t_proc_stack();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule